// File: doc/BRIEF.md
# Five-Entry Delayed-Visibility FIFO

This block is a single-clock first-in first-out queue for 4-bit words with room for exactly five entries. A word accepted on the write side is stored at once and counts toward the full flag straight away. It becomes visible to the read side only after a fixed pipeline delay. Until then the empty flag stays high and the output register keeps its old value. The read port works in show-ahead fashion: while empty is low, the output already carries the oldest visible word. A read strobe discards that word and loads the next one.

The block suits a slow control path that must see every word in arrival order and can tolerate a few cycles of delay before data is visible. Its reset is synchronous and active low. Writes offered while full and reads offered while empty are dropped without side effects. The storage pointers count modulo five, so every slot is used even though the depth is not a power of two.

Top module: `lagged_fifo`

## Requirements
- R1: Words leave on `rd_data` (4 bits) in exactly the order they were accepted, with their values unchanged.
- R2: A clock edge that samples `rst_n` low discards all contents. After that edge `empty` is 1, `full` is 0 and `rd_data` is 0.
- R3: `full` goes to 1 after the edge that accepts the fifth stored word, counting words not yet visible. It goes back to 0 after the first edge that accepts a read without a write.
- R4: A write strobe offered while `full` is 1 is ignored and leaves the stored words and their order untouched.
- R5: A read strobe offered while `empty` is 1 is ignored. No word is lost and later output order is unaffected.
- R6: If a write is accepted at edge k into a queue holding nothing, `empty` stays 1 after edges k, k+1 and k+2. It falls after edge k+3, and the written word is on `rd_data` at that point.
- R7: A read accepted at an edge moves `rd_data` to the next visible word at that same edge. If no further word is visible, `empty` rises and `rd_data` holds its value.
- R8: A read and a write accepted at the same edge leave the stored word count unchanged, as seen by the edge on which `full` later rises.
- R9: Sustained traffic through many more than five words keeps the order correct. This requires the slot pointers to wrap from slot 4 back to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 4 | Word to store |
| rd_en | input | 1 | Read strobe, sampled on the rising edge |
| rd_data | output | 4 | Registered oldest visible word |
| full | output | 1 | Five words stored |
| empty | output | 1 | No word visible to the reader |

## Verification
The assertions assume that `rst_n` is low at the first rising edge and that the strobes carry known values at every sampled edge. The latency property also assumes that a reset does not fall inside the four cycles after the write it watches. The stimulus begins with two reset cycles and changes every input only on the falling edge. It applies a mid-run reset only after the queue has been left idle long enough for any pending latency window to close. Full and empty strobes are offered freely, because the block must tolerate them.

// File: rtl/lfq_pkg.sv
// Shared defaults and helpers for the delayed-visibility FIFO.
// Assumes: depths of at least 1; widths of at least 1.
package lfq_pkg;
    parameter int unsigned LFQ_WIDTH = 4;
    parameter int unsigned LFQ_DEPTH = 5;
    parameter int unsigned LFQ_LAT   = 3;

    // Bits needed to hold values 0 .. n-1, never below one.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/lfq_ring_ptr.sv
// Modulo-DEPTH slot pointer. Gives the current slot and the slot it takes
// after this edge, so the read side can address the word it is about to show.
// Assumes: DEPTH >= 2 and AW wide enough for DEPTH-1.
module lfq_ring_ptr #(
    parameter int unsigned DEPTH = 5,
    parameter int unsigned AW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_nxt
);
    // Next slot, wrapping from the last slot back to zero.
    always_comb begin
        ptr_nxt = ptr;
        if (adv) ptr_nxt = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    end

    // Pointer register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

    assert_ptr_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        32'(ptr) < DEPTH);
endmodule

// File: rtl/lfq_store.sv
// Word storage: one synchronous write port, one combinational read port.
// Assumes: addresses below DEPTH; the caller never reads a slot in the
// cycle it is written.
module lfq_store #(
    parameter int unsigned WIDTH = 4,
    parameter int unsigned DEPTH = 5,
    parameter int unsigned AW    = 3
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store the incoming word into the addressed slot.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lfq_lag.sv
// Delay line for the "word stored" pulse. A pulse entering at edge k leaves
// in the cycle after edge k+STAGES-1.
// Assumes: STAGES >= 1.
module lfq_lag #(
    parameter int unsigned STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic pulse_out
);
    generate
        if (STAGES == 1) begin : g_one
            logic sr;
            // Single-stage delay.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= 1'b0;
                else        sr <= pulse_in;
            end
            assign pulse_out = sr;
        end else begin : g_many
            logic [STAGES-1:0] sr;
            // Multi-stage shift of the pulse.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[STAGES-2:0], pulse_in};
            end
            assign pulse_out = sr[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/lagged_fifo.sv
// Single-clock FIFO whose stored words reach the reader only after LAT edges.
// The full flag counts every stored word. The empty flag counts only the
// words that have cleared the delay. The output register shows the oldest
// visible word.
// Assumes: synchronous active-low reset held at the first edge; LAT >= 1.
module lagged_fifo
    import lfq_pkg::*;
#(
    parameter int unsigned WIDTH = LFQ_WIDTH,
    parameter int unsigned DEPTH = LFQ_DEPTH,
    parameter int unsigned LAT   = LFQ_LAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    localparam int unsigned AW = idx_bits(DEPTH);
    localparam int unsigned CW = idx_bits(DEPTH + 1);

    logic [CW-1:0]    stored_cnt, stored_nxt;
    logic [CW-1:0]    shown_cnt, shown_nxt;
    logic [AW-1:0]    wr_ptr, wr_ptr_nxt, rd_ptr, rd_ptr_nxt;
    logic [WIDTH-1:0] head_word, out_q;
    logic             wr_acc, rd_acc, arrive;

    assign full   = (stored_cnt == CW'(DEPTH));
    assign empty  = (shown_cnt == '0);
    assign wr_acc = wr_en && !full;
    assign rd_acc = rd_en && !empty;

    lfq_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .adv(wr_acc), .ptr(wr_ptr), .ptr_nxt(wr_ptr_nxt));

    lfq_ring_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .adv(rd_acc), .ptr(rd_ptr), .ptr_nxt(rd_ptr_nxt));

    lfq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .we(wr_acc), .waddr(wr_ptr), .wdata(wr_data),
        .raddr(rd_ptr_nxt), .rdata(head_word));

    lfq_lag #(.STAGES(LAT)) u_lag (
        .clk(clk), .rst_n(rst_n), .pulse_in(wr_acc), .pulse_out(arrive));

    // Next-state counts for stored and visible words.
    always_comb begin
        stored_nxt = stored_cnt + CW'(wr_acc) - CW'(rd_acc);
        shown_nxt  = shown_cnt + CW'(arrive) - CW'(rd_acc);
    end

    // Occupancy counters and the registered output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stored_cnt <= '0;
            shown_cnt  <= '0;
            out_q      <= '0;
        end else begin
            stored_cnt <= stored_nxt;
            shown_cnt  <= shown_nxt;
            if (shown_nxt != '0) out_q <= head_word;
        end
    end

    assign rd_data = out_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(stored_cnt) <= DEPTH);

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_shown_le_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shown_cnt <= stored_cnt);

    assert_full_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en) |=> $stable(wr_ptr));

    assert_empty_read_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rd_ptr));

    assert_both_keep_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && rd_acc) |=> $stable(stored_cnt));

    generate
        if (LAT == 3) begin : g_lat3_chk
            assert_first_word_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_acc && stored_cnt == '0) |=> empty ##1 empty ##1 empty ##1 !empty);
        end
    endgenerate
endmodule

// File: tb/lagged_fifo_bench.sv
// Self-checking bench: drives directed and swept strobe patterns and
// compares against an arithmetic queue model kept in the bench.
module lagged_fifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] rd_data;
    logic       full, empty;

    int    nchk = 0;
    int    nfail = 0;
    string cur_tag = "R2";

    // Bench-side model state.
    int q[$];
    int mcnt = 0;
    int mvis = 0;
    int pend[3] = '{0, 0, 0};
    int exp_dout = 0;

    always #4 clk = ~clk;

    lagged_fifo u_lagged_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty));

    task automatic check(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge,
    // and compare at the next falling edge.
    task automatic step(input logic w, input logic r, input int d, input logic rst);
        int wa, ra, arr;
        rst_n   = ~rst;
        wr_en   = w;
        rd_en   = r;
        wr_data = 4'(d);
        @(posedge clk);
        if (rst) begin
            q.delete();
            mcnt = 0; mvis = 0; pend = '{0, 0, 0}; exp_dout = 0;
        end else begin
            wa  = (w && mcnt < 5) ? 1 : 0;
            ra  = (r && mvis > 0) ? 1 : 0;
            arr = pend[2];
            if (ra != 0) void'(q.pop_front());
            if (wa != 0) q.push_back(d & 15);
            pend[2] = pend[1];
            pend[1] = pend[0];
            pend[0] = wa;
            mvis = mvis + arr - ra;
            mcnt = mcnt + wa - ra;
            if (mvis > 0) exp_dout = q[0];
        end
        @(negedge clk);
        check(cur_tag, "empty", int'(empty), (mvis == 0) ? 1 : 0);
        check(cur_tag, "full", int'(full), (mcnt == 5) ? 1 : 0);
        check(cur_tag, "rd_data", int'(rd_data), exp_dout);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        cur_tag = "R2";
        step(1'b0, 1'b0, 0, 1'b1);
        step(1'b1, 1'b1, 9, 1'b1);

        // R6: first word into an empty queue shows up after the fourth edge.
        cur_tag = "R6";
        step(1'b1, 1'b0, 10, 1'b0);
        idle(4);

        // R7: reading the last visible word raises empty and holds the data.
        cur_tag = "R7";
        step(1'b0, 1'b1, 0, 1'b0);
        idle(2);

        // R3: five back-to-back writes reach full on the fifth edge.
        cur_tag = "R3";
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 3 + i * 2, 1'b0);
        idle(3);

        // R4: writes offered while full are dropped.
        cur_tag = "R4";
        step(1'b1, 1'b0, 15, 1'b0);
        step(1'b1, 1'b0, 14, 1'b0);

        // R1: drain in order, one word per read.
        cur_tag = "R1";
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 0, 1'b0);

        // R5: reads offered while empty are dropped.
        cur_tag = "R5";
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 0, 1'b0);
        step(1'b1, 1'b0, 6, 1'b0);
        idle(4);
        step(1'b0, 1'b1, 0, 1'b0);

        // R8: simultaneous read and write hold the count, then fill to full.
        cur_tag = "R8";
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1 + i, 1'b0);
        idle(3);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 8 + i, 1'b0);
        step(1'b1, 1'b0, 13, 1'b0);
        idle(3);

        // R2: mid-run reset discards contents, and the delay restarts cleanly.
        cur_tag = "R2";
        step(1'b0, 1'b0, 0, 1'b1);
        step(1'b1, 1'b0, 11, 1'b0);
        idle(4);

        // R9: long swept traffic across every strobe combination, wrapping many times.
        cur_tag = "R9";
        for (int i = 0; i < 800; i++) begin
            step(((i * 7) % 5) < 3, ((i * 11) % 7) < ((i / 100) % 2 == 0 ? 3 : 5), i * 3, 1'b0);
        end
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule